// File: doc/BRIEF.md
# Execute-Stage ALU with Fused Shifter and Jump Condition

This block is the execute datapath of a small 32-bit RISC pipeline. Each cycle it takes two operands, a 3-bit function code, a 4-bit operation code and a 5-bit count. It forms a sum, a difference or one of six bitwise combinations of the operands. Depending on the operation code, it then shifts or rotates that value by the count, or passes it through unchanged. For the conditional-jump operation codes it also decides from the value and the adder carry whether the jump is taken.

The datapath itself is combinational. Its three results are captured in a single output register stage, so a decoded instruction presented on one rising edge has its result, carry and jump decision on the outputs after that edge. An asynchronous active-low reset clears the register stage. The data width is a parameter and must be a power of two. The count width is derived from it.

Top module: `exec_alu_stage`

## Requirements
- R1: Outputs reflect the inputs present at the previous rising clock edge. While `rst_n` is low, `result`, `carry` and `jump_taken` are all 0.
- R2: Function code 0 gives A+B, with `carry` equal to the carry out of bit 31. Function code 1 gives A−B, computed as A + ~B + 1, with `carry` equal to the carry out of that sum (1 means no borrow).
- R3: Function codes 2 to 7 give A&B, A&~B, A|B, A|~B, A^B and A^~B in that order, and `carry` is 0 for each of them.
- R4: Operation code 0 shifts the function value right logically by the count, and operation code 1 shifts it left logically. Vacated bits are 0.
- R5: Operation code 2 rotates the function value right by the count, and operation code 3 rotates it left. No bit is lost.
- R6: Operation code 4 shifts the function value right arithmetically by the count, and vacated bits copy bit 31.
- R7: The count covers 0 to 31. A count of 0 under operation codes 0 to 4 returns the function value unchanged.
- R8: Operation codes 5, 6, 7 and 8 pass the function value unshifted, whatever the count, and `jump_taken` is 0. Operation codes 0 to 4 also give `jump_taken` = 0.
- R9: Operation codes 9 to 15 pass the function value unshifted. Code 9 is taken when bit 31 of that value is 1, and code 13 is taken when bit 31 is 0.
- R10: Operation code 10 is taken when the value is zero, and operation code 14 is taken when it is nonzero.
- R11: Operation code 11 is taken when `carry` is 1, and operation code 15 is taken when `carry` is 0.
- R12: Operation code 12 is always taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| fn_sel | input | 3 | Function code (0 to 7) |
| op_sel | input | 4 | Operation code: shift kind, pass or jump condition |
| count | input | 5 | Shift or rotate amount |
| result | output | 32 | Registered final value |
| carry | output | 1 | Registered adder carry |
| jump_taken | output | 1 | Registered jump decision |

## Verification
Two functions resolve in the same cycle: the adder and the jump condition. The carry and the zero and sign flags that a jump tests come from the sum formed in that same cycle, so a wrong carry polarity or a wrong zero detect shows up only when both act together. The bench provokes this by sweeping every function code against every jump code over operand pairs chosen for equality, borrow and overflow, such as equal operands subtracted and all-ones plus one. It judges each case against an independent bit-by-bit reference, with hand-worked directed cases on top.

// File: rtl/exec_pkg.sv
package exec_pkg;

    typedef enum logic [2:0] {
        FN_ADD  = 3'd0,
        FN_SUB  = 3'd1,
        FN_AND  = 3'd2,
        FN_ANDN = 3'd3,
        FN_OR   = 3'd4,
        FN_ORN  = 3'd5,
        FN_XOR  = 3'd6,
        FN_XNOR = 3'd7
    } fn_e;

    typedef enum logic [3:0] {
        OP_SRL     = 4'd0,
        OP_SLL     = 4'd1,
        OP_ROR     = 4'd2,
        OP_ROL     = 4'd3,
        OP_SRA     = 4'd4,
        OP_PASS    = 4'd5,
        OP_RSV6    = 4'd6,
        OP_RSV7    = 4'd7,
        OP_RSV8    = 4'd8,
        OP_JNEG    = 4'd9,
        OP_JZERO   = 4'd10,
        OP_JCARRY  = 4'd11,
        OP_JALWAYS = 4'd12,
        OP_JNNEG   = 4'd13,
        OP_JNZERO  = 4'd14,
        OP_JNCARRY = 4'd15
    } op_e;

    // Shifter control decoded from the operation code
    typedef struct packed {
        logic enable;   // apply count at all
        logic left;     // operate on bit-reversed value
        logic rotate;   // wrap bits instead of filling
        logic arith;    // fill with sign bit (right only)
    } shctl_t;

endpackage

// File: rtl/exec_fn_unit.sv
module exec_fn_unit
    import exec_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  fn_e          fn,
    output logic [W-1:0] y,
    output logic         cy
);

    // Odd codes all use the complemented second operand
    logic         inv_b;
    logic [W-1:0] b_m;
    logic [W:0]   sum;

    assign inv_b = fn[0];
    assign b_m   = inv_b ? ~b : b;
    assign sum   = {1'b0, a} + {1'b0, b_m} + {{W{1'b0}}, inv_b};

    always_comb begin
        y  = '0;
        cy = 1'b0;
        unique case (fn[2:1])
            2'd0: begin
                y  = sum[W-1:0];
                cy = sum[W];
            end
            2'd1: y = a & b_m;
            2'd2: y = a | b_m;
            2'd3: y = a ^ b_m;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/exec_shifter.sv
module exec_shifter
    import exec_pkg::*;
#(
    parameter int unsigned W  = 32,
    parameter int unsigned CW = $clog2(W)
) (
    input  logic [W-1:0]  x,
    input  logic [CW-1:0] amt,
    input  shctl_t        ctl,
    output logic [W-1:0]  y
);

    logic [W-1:0] x_rev;
    logic [W-1:0] pre;
    logic [W-1:0] post;
    logic [W-1:0] post_rev;
    logic         fill;
    logic [W-1:0] stg [0:CW];

    // Left operations run through the right-going network on reversed bits
    for (genvar i = 0; i < W; i++) begin : g_rev
        assign x_rev[i]    = x[W-1-i];
        assign post_rev[i] = post[W-1-i];
    end

    assign pre    = ctl.left ? x_rev : x;
    assign fill   = ctl.arith & ~ctl.left & x[W-1];
    assign stg[0] = pre;

    for (genvar k = 0; k < CW; k++) begin : g_stage
        localparam int unsigned S = 1 << k;
        logic [W-1:0] moved;
        assign moved = ctl.rotate ? {stg[k][S-1:0], stg[k][W-1:S]}
                                  : {{S{fill}}, stg[k][W-1:S]};
        assign stg[k+1] = amt[k] ? moved : stg[k];
    end

    assign post = stg[CW];
    assign y    = !ctl.enable ? x : (ctl.left ? post_rev : post);

endmodule

// File: rtl/exec_cond.sv
module exec_cond
    import exec_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  op_e          op,
    input  logic [W-1:0] val,
    input  logic         cy,
    output logic         taken
);

    logic is_neg;
    logic is_zero;

    assign is_neg  = val[W-1];
    assign is_zero = ~|val;

    always_comb begin
        unique case (op)
            OP_JNEG:    taken = is_neg;
            OP_JZERO:   taken = is_zero;
            OP_JCARRY:  taken = cy;
            OP_JALWAYS: taken = 1'b1;
            OP_JNNEG:   taken = ~is_neg;
            OP_JNZERO:  taken = ~is_zero;
            OP_JNCARRY: taken = ~cy;
            default:    taken = 1'b0;
        endcase
    end

endmodule

// File: rtl/exec_alu_stage.sv
module exec_alu_stage
    import exec_pkg::*;
#(
    parameter int unsigned W  = 32,
    parameter int unsigned CW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  opnd_a,
    input  logic [W-1:0]  opnd_b,
    input  logic [2:0]    fn_sel,
    input  logic [3:0]    op_sel,
    input  logic [CW-1:0] count,
    output logic [W-1:0]  result,
    output logic          carry,
    output logic          jump_taken
);

    fn_e          fn;
    op_e          op;
    shctl_t       shctl;
    logic [W-1:0] fn_val;
    logic         fn_cy;
    logic [W-1:0] sh_val;
    logic         jmp;

    assign fn = fn_e'(fn_sel);
    assign op = op_e'(op_sel);

    // Operation code to shifter control
    always_comb begin
        shctl = '0;
        unique case (op)
            OP_SRL:  shctl = '{enable: 1'b1, left: 1'b0, rotate: 1'b0, arith: 1'b0};
            OP_SLL:  shctl = '{enable: 1'b1, left: 1'b1, rotate: 1'b0, arith: 1'b0};
            OP_ROR:  shctl = '{enable: 1'b1, left: 1'b0, rotate: 1'b1, arith: 1'b0};
            OP_ROL:  shctl = '{enable: 1'b1, left: 1'b1, rotate: 1'b1, arith: 1'b0};
            OP_SRA:  shctl = '{enable: 1'b1, left: 1'b0, rotate: 1'b0, arith: 1'b1};
            default: shctl = '0;
        endcase
    end

    exec_fn_unit #(.W(W)) u_fn (
        .a  (opnd_a),
        .b  (opnd_b),
        .fn (fn),
        .y  (fn_val),
        .cy (fn_cy)
    );

    exec_shifter #(.W(W), .CW(CW)) u_sh (
        .x   (fn_val),
        .amt (count),
        .ctl (shctl),
        .y   (sh_val)
    );

    exec_cond #(.W(W)) u_cond (
        .op    (op),
        .val   (sh_val),
        .cy    (fn_cy),
        .taken (jmp)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result     <= '0;
            carry      <= 1'b0;
            jump_taken <= 1'b0;
        end else begin
            result     <= sh_val;
            carry      <= fn_cy;
            jump_taken <= jmp;
        end
    end

endmodule

// File: rtl/exec_alu_stage_chk.sv
module exec_alu_stage_chk #(
    parameter int unsigned W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] opnd_a,
    input logic [W-1:0] opnd_b,
    input logic [2:0]   fn_sel,
    input logic [3:0]   op_sel,
    input logic [W-1:0] result,
    input logic         carry,
    input logic         jump_taken
);

    assert_logic_no_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fn_sel[2:1]) != 2'd0) |-> !carry);

    assert_shift_never_jumps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel) < 4'd9) |-> !jump_taken);

    assert_always_taken_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel) == 4'd12) |-> jump_taken);

    assert_sign_jump_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel) == 4'd9) |-> (jump_taken == result[W-1]));

    assert_nonneg_jump_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel) == 4'd13) |-> (jump_taken == !result[W-1]));

    assert_zero_jump_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel) == 4'd10) |-> (jump_taken == (result == '0)));

    assert_nonzero_jump_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel) == 4'd14) |-> (jump_taken == (result != '0)));

    assert_carry_jump_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel) == 4'd11) |-> (jump_taken == carry));

    assert_nocarry_jump_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel) == 4'd15) |-> (jump_taken == !carry));

    assert_rotate_keeps_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fn_sel) == 3'd6 && ($past(op_sel) == 4'd2 || $past(op_sel) == 4'd3))
        |-> ($countones(result) == $countones($past(opnd_a ^ opnd_b))));

    assert_pass_unshifted_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fn_sel) == 3'd4 && $past(op_sel) >= 4'd5)
        |-> (result == $past(opnd_a | opnd_b)));

endmodule

bind exec_alu_stage exec_alu_stage_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b),
    .fn_sel     (fn_sel),
    .op_sel     (op_sel),
    .result     (result),
    .carry      (carry),
    .jump_taken (jump_taken)
);

// File: tb/exec_alu_stage_bench.sv
`timescale 1ns/1ps
module exec_alu_stage_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [2:0]  fn_sel = '0;
    logic [3:0]  op_sel = '0;
    logic [4:0]  count = '0;
    logic [31:0] result;
    logic        carry;
    logic        jump_taken;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    exec_alu_stage u_exec_alu_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .fn_sel     (fn_sel),
        .op_sel     (op_sel),
        .count      (count),
        .result     (result),
        .carry      (carry),
        .jump_taken (jump_taken)
    );

    // Operand pairs {A, B}
    localparam logic [63:0] PAIRS [8] = '{
        {32'h0000_0000, 32'h0000_0000},
        {32'hFFFF_FFFF, 32'h0000_0001},
        {32'h0000_0005, 32'h0000_0005},
        {32'h0000_0003, 32'h0000_0005},
        {32'h8000_0000, 32'h8000_0000},
        {32'h7FFF_FFFF, 32'h0000_0001},
        {32'hDEAD_BEEF, 32'h1234_5678},
        {32'hA5A5_0F0F, 32'hFFFF_0000}
    };
    localparam logic [4:0] COUNTS [5] = '{5'd0, 5'd1, 5'd7, 5'd16, 5'd31};

    // Independent reference
    function automatic logic [32:0] ref_fn(logic [31:0] a, logic [31:0] b, logic [2:0] f);
        logic [32:0] r;
        case (f)
            3'd0: r = {1'b0, a} + {1'b0, b};
            3'd1: r = {1'b0, a} + {1'b0, ~b} + 33'd1;
            3'd2: r = {1'b0, a & b};
            3'd3: r = {1'b0, a & ~b};
            3'd4: r = {1'b0, a | b};
            3'd5: r = {1'b0, a | ~b};
            3'd6: r = {1'b0, a ^ b};
            default: r = {1'b0, ~(a ^ b)};
        endcase
        return r;
    endfunction

    function automatic logic [31:0] ref_sh(logic [31:0] x, logic [3:0] op, int c);
        logic [31:0] r;
        r = x;
        if (op <= 4'd4) begin
            for (int i = 0; i < 32; i++) begin
                case (op)
                    4'd0: r[i] = (i + c < 32) ? x[i + c] : 1'b0;
                    4'd1: r[i] = (i >= c) ? x[i - c] : 1'b0;
                    4'd2: r[i] = x[(i + c) % 32];
                    4'd3: r[i] = x[(i - c + 32) % 32];
                    default: r[i] = (i + c < 32) ? x[i + c] : x[31];
                endcase
            end
        end
        return r;
    endfunction

    function automatic logic ref_jmp(logic [31:0] v, logic cy, logic [3:0] op);
        case (op)
            4'd9:  return v[31];
            4'd10: return v == 32'd0;
            4'd11: return cy;
            4'd12: return 1'b1;
            4'd13: return !v[31];
            4'd14: return v != 32'd0;
            4'd15: return !cy;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string res_tag(logic [2:0] f, logic [3:0] op);
        if (op == 4'd0 || op == 4'd1) return "R4";
        if (op == 4'd2 || op == 4'd3) return "R5";
        if (op == 4'd4) return "R6";
        if (op >= 4'd5 && op <= 4'd8) return "R8";
        if (op >= 4'd9) return "R9";
        return (f < 3'd2) ? "R2" : "R3";
    endfunction

    function automatic string jmp_tag(logic [3:0] op);
        if (op == 4'd9 || op == 4'd13) return "R9";
        if (op == 4'd10 || op == 4'd14) return "R10";
        if (op == 4'd11 || op == 4'd15) return "R11";
        if (op == 4'd12) return "R12";
        return "R8";
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic apply(logic [31:0] a, logic [31:0] b, logic [2:0] f, logic [3:0] op, logic [4:0] c);
        @(negedge clk);
        opnd_a = a; opnd_b = b; fn_sel = f; op_sel = op; count = c;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        // R1: reset holds outputs at zero despite active inputs
        opnd_a = 32'hFFFF_FFFF; opnd_b = 32'h1; fn_sel = 3'd0; op_sel = 4'd12;
        repeat (3) @(negedge clk);
        check("R1", "reset result", result, 32'h0);
        check("R1", "reset carry", {31'd0, carry}, 32'h0);
        check("R1", "reset jump", {31'd0, jump_taken}, 32'h0);
        rst_n = 1'b1;

        // Table walk against the reference model
        for (int p = 0; p < 8; p++) begin
            for (int f = 0; f < 8; f++) begin
                for (int op = 0; op < 16; op++) begin
                    for (int ci = 0; ci < 5; ci++) begin
                        logic [31:0] a, b, ev;
                        logic [32:0] fr;
                        logic        ej;
                        a  = PAIRS[p][63:32];
                        b  = PAIRS[p][31:0];
                        fr = ref_fn(a, b, 3'(f));
                        ev = ref_sh(fr[31:0], 4'(op), int'(COUNTS[ci]));
                        ej = (op >= 9) ? ref_jmp(ev, fr[32], 4'(op)) : 1'b0;
                        apply(a, b, 3'(f), 4'(op), COUNTS[ci]);
                        check(res_tag(3'(f), 4'(op)), "result", result, ev);
                        check((f < 2) ? "R2" : "R3", "carry", {31'd0, carry}, {31'd0, fr[32]});
                        check(jmp_tag(4'(op)), "jump", {31'd0, jump_taken}, {31'd0, ej});
                    end
                end
            end
        end

        // Directed corner cases with worked values
        apply(32'hFFFF_FFFF, 32'h1, 3'd0, 4'd5, 5'd9);
        check("R2", "add wrap result", result, 32'h0);
        check("R2", "add wrap carry", {31'd0, carry}, 32'h1);

        apply(32'h5, 32'h5, 3'd1, 4'd10, 5'd0);
        check("R10", "equal sub zero jump", {31'd0, jump_taken}, 32'h1);
        check("R2", "equal sub carry", {31'd0, carry}, 32'h1);

        apply(32'h3, 32'h5, 3'd1, 4'd11, 5'd0);
        check("R2", "borrow result", result, 32'hFFFF_FFFE);
        check("R11", "borrow carry jump", {31'd0, jump_taken}, 32'h0);
        apply(32'h3, 32'h5, 3'd1, 4'd15, 5'd0);
        check("R11", "borrow no-carry jump", {31'd0, jump_taken}, 32'h1);

        apply(32'h0, 32'hFFFF_FFFF, 3'd5, 4'd5, 5'd0);
        check("R3", "or-not", result, 32'h0);
        apply(32'h0, 32'h0, 3'd7, 4'd5, 5'd0);
        check("R3", "xnor", result, 32'hFFFF_FFFF);

        apply(32'h8000_0000, 32'h0, 3'd4, 4'd4, 5'd31);
        check("R6", "sra full", result, 32'hFFFF_FFFF);
        apply(32'h8000_0001, 32'h0, 3'd4, 4'd3, 5'd1);
        check("R5", "rotl 1", result, 32'h0000_0003);
        apply(32'h8000_0001, 32'h0, 3'd4, 4'd2, 5'd1);
        check("R5", "rotr 1", result, 32'hC000_0000);
        apply(32'h1, 32'h0, 3'd4, 4'd1, 5'd31);
        check("R4", "sll 31", result, 32'h8000_0000);
        apply(32'h8000_0000, 32'h0, 3'd4, 4'd0, 5'd0);
        check("R7", "count zero", result, 32'h8000_0000);

        apply(32'h8000_0000, 32'h0, 3'd4, 4'd9, 5'd4);
        check("R9", "neg jump unshifted", result, 32'h8000_0000);
        check("R9", "neg jump", {31'd0, jump_taken}, 32'h1);
        apply(32'h8000_0000, 32'h0, 3'd4, 4'd13, 5'd4);
        check("R9", "nonneg jump", {31'd0, jump_taken}, 32'h0);

        apply(32'h0, 32'h0, 3'd2, 4'd12, 5'd0);
        check("R12", "always", {31'd0, jump_taken}, 32'h1);

        apply(32'h1, 32'h0, 3'd0, 4'd6, 5'd3);
        check("R8", "reserved pass", result, 32'h1);
        check("R8", "reserved no jump", {31'd0, jump_taken}, 32'h0);

        // R1: reset reapplied mid-run clears outputs
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1", "async reset result", result, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        finish_run();
    end

endmodule